// File: doc/BRIEF.md
# External Event Down-Counter with Edge Interrupts

This block is a 16-bit down-counter whose clock enable comes from an external, asynchronous event pin. The pin is brought into the internal clock domain by a synchronizer. An edge detector on the synchronized level produces one count pulse per event. A control bit selects whether rising or falling edges count. When the counter steps below zero, it reloads from a software-written reload register and latches a pending flag.

A second asynchronous pin does not touch the counter. It serves as an independent rising-edge interrupt source with its own enable and its own pending flag. A single interrupt line combines both sources, each gated by its enable.

Software reaches the block through a small register port. Writes take effect at the clock edge. Read data is registered and appears one clock after the address is presented. Pending flags stay set until software writes 0 to them. An event that lands in the same clock as a clear wins, so no event is lost.

Top module: `evt_down_counter`

## Requirements
- R1: After reset, every register reads 0 (COUNT at address 0, RELOAD at address 1, CTRL at address 2, FLAGS at address 3), and irq is 0.
- R2: With CTRL bit 0 (falling-select) at 0, each rising edge on pin_a decrements COUNT by one, and falling edges leave COUNT unchanged.
- R3: With CTRL bit 0 at 1, each falling edge on pin_a decrements COUNT by one, and rising edges leave COUNT unchanged.
- R4: pin_a passes through a two-stage synchronizer, and a level held on pin_a for any number of cycles is counted exactly once.
- R5: A qualified edge while COUNT is 0 loads COUNT from RELOAD and sets FLAGS bit 0 (pend_a).
- R6: A pending flag stays set until software writes 0 to its bit in FLAGS (bit 0 for pend_a, bit 1 for pend_b). Writing 1 to a bit has no effect.
- R7: A rising edge on pin_b sets FLAGS bit 1 only while CTRL bit 2 (en_b) is 1. pin_b never changes COUNT.
- R8: pend_a is set by an underflow regardless of CTRL bit 1 (en_a).
- R9: irq is a register equal, one clock later, to (en_a & pend_a) | (en_b & pend_b).
- R10: When a flag set event and a software clear of that flag fall in the same clock, the flag stays set.
- R11: A software write to COUNT in the same clock as a qualified edge wins. COUNT takes the written value, and no underflow or pend_a set occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address, for both read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data of the register at addr |
| pin_a | input | 1 | Asynchronous count event input |
| pin_b | input | 1 | Asynchronous rising-edge interrupt input |
| irq | output | 1 | Registered interrupt request |

## Verification
Two collisions are provoked. In the first, a software clear of pend_a meets the underflow that sets it. In the second, a software write to COUNT meets a qualified count edge. The bench changes pin_a at a known clock and issues the register write exactly two clocks later, so that the write lands on the edge where the synchronized event takes effect. The collision is judged through readback: pend_a must still be set with COUNT reloaded in the first case. In the second, COUNT must hold the written value with pend_a clear.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd3;

  localparam int N_FLAGS = 2;
  localparam int FLAG_A  = 0;
  localparam int FLAG_B  = 1;

  typedef struct packed {
    logic en_b;      // bit 2
    logic en_a;      // bit 1
    logic fall_sel;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[MSB];
    end
  end

  assign rise = sync_q[MSB] & ~prev_q;
  assign fall = ~sync_q[MSB] & prev_q;
endmodule

// File: rtl/evt_down_cnt.sv
module evt_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count,
  output logic         uflow
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign uflow   = tick & ~load & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (uflow) begin
      count <= reload_val;
    end else if (tick) begin
      count <= count - W'(1);
    end
  end
endmodule

// File: rtl/evt_pend_flag.sv
module evt_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              pin_a,
  input  logic              pin_b,
  output logic              irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   reload_q;
  logic [CNT_W-1:0]   count;
  logic               rise_a, fall_a, rise_b, fall_b;
  logic               cnt_tick, cnt_load, uflow;
  logic [N_FLAGS-1:0] set_v, clr_v, pend;

  evt_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_a (
    .clk(clk), .rst(rst), .pin(pin_a), .rise(rise_a), .fall(fall_a)
  );

  evt_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_b (
    .clk(clk), .rst(rst), .pin(pin_b), .rise(rise_b), .fall(fall_b)
  );

  assign cnt_tick = ctrl_q.fall_sel ? fall_a : rise_a;
  assign cnt_load = wr_en && (addr == A_COUNT);

  evt_down_cnt #(.W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .tick(cnt_tick), .load(cnt_load),
    .load_val(wdata), .reload_val(reload_q), .count(count), .uflow(uflow)
  );

  // Flag event sources; the falling edge of pin_b has no use.
  assign set_v[FLAG_A] = uflow;
  assign set_v[FLAG_B] = rise_b & ctrl_q.en_b;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    assign clr_v[i] = wr_en && (addr == A_FLAGS) && !wdata[i];
    evt_pend_flag i_flag (
      .clk(clk), .rst(rst), .set(set_v[i]), .clr(clr_v[i]), .q(pend[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (addr == A_RELOAD) reload_q <= wdata;
      if (addr == A_CTRL)   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= (ctrl_q.en_a & pend[FLAG_A]) | (ctrl_q.en_b & pend[FLAG_B]);
      case (addr)
        A_COUNT:  rdata <= count;
        A_RELOAD: rdata <= reload_q;
        A_CTRL:   rdata <= CNT_W'(ctrl_q);
        default:  rdata <= CNT_W'(pend);
      endcase
    end
  end
endmodule

// File: rtl/evt_down_counter_chk.sv
module evt_down_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic [W-1:0] reload,
  input logic [W-1:0] count,
  input logic [1:0]   pend,
  input logic [1:0]   set_v,
  input logic [1:0]   clr_v,
  input logic         en_a,
  input logic         en_b,
  input logic         rise_b,
  input logic         irq
);
  p_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && count != '0) |=> count == $past(count) - W'(1));

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(count));

  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && count == '0) |=> (count == $past(reload) && pend[0]));

  p_hold_a_r6: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && !clr_v[0]) |=> pend[0]);

  p_hold_b_r6: assert property (@(posedge clk) disable iff (rst)
    (pend[1] && !clr_v[1]) |=> pend[1]);

  p_b_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[1]) |-> $past(en_b && rise_b));

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == (($past(en_a) & $past(pend[0])) | ($past(en_b) & $past(pend[1]))));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (set_v[0] && clr_v[0]) |=> pend[0]);

  p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));
endmodule

bind evt_down_counter evt_down_counter_chk #(.W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .tick(cnt_tick), .load(cnt_load), .load_val(wdata),
  .reload(reload_q), .count(count), .pend(pend), .set_v(set_v), .clr_v(clr_v),
  .en_a(ctrl_q.en_a), .en_b(ctrl_q.en_b), .rise_b(rise_b), .irq(irq)
);

// File: tb/test_evt_down_counter.sv
module test_evt_down_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pin_a = 1'b0;
  logic        pin_b = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  evt_down_counter i_evt_down_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic set_a(input logic v);
    pin_a = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_b(input logic v);
    pin_b = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_a(input int high_cycles);
    pin_a = 1'b1;
    repeat (high_cycles) @(negedge clk);
    set_a(1'b0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), d);
      check("R1 reset register", d, 16'h0);
    end
    check("R1 reset irq", 16'(irq), 16'h0);
  endtask

  task automatic t_rise();
    logic [15:0] d;
    wr(2'd1, 16'd100);
    wr(2'd0, 16'd10);
    for (int i = 0; i < 3; i++) pulse_a(4);
    rd(2'd0, d);
    check("R2 three rising edges", d, 16'd7);
    set_a(1'b1);
    rd(2'd0, d);
    check("R2 rising edge counted", d, 16'd6);
    repeat (20) @(negedge clk);
    set_a(1'b0);
    rd(2'd0, d);
    check("R4 long level counted once", d, 16'd6);
  endtask

  task automatic t_fall();
    logic [15:0] d;
    wr(2'd2, 16'h0001);
    set_a(1'b1);
    rd(2'd0, d);
    check("R3 rising ignored", d, 16'd6);
    set_a(1'b0);
    rd(2'd0, d);
    check("R3 falling counted", d, 16'd5);
  endtask

  task automatic t_underflow();
    logic [15:0] d;
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'd4);
    wr(2'd0, 16'd1);
    pulse_a(4);
    rd(2'd0, d);
    check("R5 reaches zero", d, 16'd0);
    rd(2'd3, d);
    check("R5 no flag at zero", d, 16'h0);
    pulse_a(4);
    rd(2'd0, d);
    check("R5 reload on underflow", d, 16'd4);
    rd(2'd3, d);
    check("R8 pend_a set with en_a off", d, 16'h1);
    check("R9 irq off while en_a off", 16'(irq), 16'h0);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    wr(2'd3, 16'h0003);
    rd(2'd3, d);
    check("R6 writing 1 keeps flag", d, 16'h1);
    wr(2'd3, 16'h0002);
    rd(2'd3, d);
    check("R6 writing 0 clears flag", d, 16'h0);
  endtask

  task automatic t_pin_b();
    logic [15:0] d;
    set_b(1'b1); set_b(1'b0);
    rd(2'd3, d);
    check("R7 pin_b ignored with en_b off", d, 16'h0);
    wr(2'd2, 16'h0004);
    set_b(1'b1);
    rd(2'd3, d);
    check("R7 pin_b rise sets pend_b", d, 16'h2);
    set_b(1'b0);
    rd(2'd0, d);
    check("R7 pin_b leaves count", d, 16'd4);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    check("R9 irq from pend_b", 16'(irq), 16'h1);
    wr(2'd3, 16'h0001);
    @(negedge clk);
    check("R9 irq drops after clear", 16'(irq), 16'h0);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'd3);
    wr(2'd0, 16'd0);
    pulse_a(4);
    check("R9 irq off, en_a off", 16'(irq), 16'h0);
    wr(2'd2, 16'h0002);
    @(negedge clk);
    check("R9 irq from pend_a", 16'(irq), 16'h1);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0000);
    rd(2'd3, d);
    check("R6 both flags cleared", d, 16'h0);
  endtask

  task automatic t_clear_collide();
    logic [15:0] d;
    wr(2'd1, 16'd6);
    wr(2'd0, 16'd0);
    pin_a = 1'b1;
    repeat (2) @(negedge clk);
    wr(2'd3, 16'h0000);
    rd(2'd3, d);
    check("R10 set beats clear", d, 16'h1);
    rd(2'd0, d);
    check("R10 reload at collision", d, 16'd6);
    set_a(1'b0);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_load_collide();
    logic [15:0] d;
    wr(2'd0, 16'd0);
    pin_a = 1'b1;
    repeat (2) @(negedge clk);
    wr(2'd0, 16'd9);
    rd(2'd0, d);
    check("R11 write beats edge", d, 16'd9);
    rd(2'd3, d);
    check("R11 no underflow flag", d, 16'h0);
    set_a(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_underflow();
    t_clear();
    t_pin_b();
    t_irq();
    t_clear_collide();
    t_load_collide();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule